// File: doc/BRIEF.md
# ADC Sample-and-Convert Sequencer

This block paces an external sample-and-hold stage and a successive-approximation converter through an endless acquisition loop. The loop has three steps. First it holds the analog value with a sample-control output. Next it raises a start-of-conversion output for a single step. Then it waits for the converter to report end of conversion. When the converter is done, the sequencer latches the 8-bit conversion word into a registered output bus, which can drive a bank of LEDs, and starts the loop again.

All registers run on one system clock. The machine moves forward only when a single-cycle step-enable pulse arrives. That pulse comes from a slow divider outside this block, so each phase can be watched by eye. The end-of-conversion line comes from another device, so it passes through a two-flop synchronizer before the sequencer uses it. Reset comes from an active-low push button. It takes effect at once and is released in step with the clock.

Top module: `adc_seq_top`

## Requirements
- R1: While rst_n is low, sample_o, soc_o and result_o are all 0, and this holds without waiting for a clock edge. After release the machine is in the sampling phase: sample_o goes to 1 within four clock edges of rst_n rising, and the first step moves to the start phase.
- R2: sample_o is 1 only during the sampling phase and soc_o is 1 only during the start phase. The two are never 1 together, and each output follows its phase one clock after the phase is entered.
- R3: With no step_en pulse, the phase does not change. On step_en the phases advance in the order sampling, then start, then converting.
- R4: While the synchronized end-of-conversion is 0, every step taken in the converting phase leaves the machine in that phase, however many steps go by.
- R5: A step taken in the converting phase while the synchronized end-of-conversion is 1 loads the value on conv_data_i at that clock edge into result_o and returns the machine to the sampling phase. A change on conv_data_i right after that edge is not captured.
- R6: result_o holds its value between captures. An end-of-conversion level of 1 during the sampling or start phase does not cause a capture and does not skip a phase.
- R7: eoc_i goes through two flops. A step at the first or second clock edge after eoc_i rises still sees the old 0 and stalls. A step at the third edge sees the 1.
- R8: Pulling rst_n low in any phase, including the middle of a conversion, clears result_o to 0 and returns the machine to the sampling phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low push-button reset, asynchronous assert |
| step_en | input | 1 | One-cycle pulse at the slow step rate |
| eoc_i | input | 1 | End of conversion from the converter, asynchronous |
| conv_data_i | input | DATA_W | Conversion word from the converter |
| sample_o | output | 1 | Sample-and-hold control, high in the sampling phase |
| soc_o | output | 1 | Start-of-conversion, high in the start phase |
| result_o | output | DATA_W | Last captured conversion word |

## Verification
Two things can happen on the same step edge: the result capture and the return to the sampling phase. The conversion word can also change right at that edge. Every step in the bench moves conv_data_i to its complement on the half cycle after the step edge. The scoreboard checks that the word present at the edge is the one latched, and that sample_o comes back one clock later. A second overlap is a rise on eoc_i in the same cycle as a step. The bench judges this by the stall it must cause at the first two edges and the capture at the third.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PH_SAMPLE = 2'd0,
    PH_START  = 2'd1,
    PH_CONV   = 2'd2
  } seq_phase_e;

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= RST_VAL;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[LAST-1:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[LAST];

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic step_en,
  input  logic eoc_s,
  output logic capture_o,
  output logic sample_o,
  output logic soc_o
);

  seq_phase_e phase_q, phase_d;
  logic       sample_q, soc_q;

  always_comb begin
    phase_d = phase_q;
    if (step_en) begin
      case (phase_q)
        PH_SAMPLE: phase_d = PH_START;
        PH_START:  phase_d = PH_CONV;
        PH_CONV:   if (eoc_s) phase_d = PH_SAMPLE;
        default:   phase_d = PH_SAMPLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_SAMPLE;
    else         phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= 1'b0;
      soc_q    <= 1'b0;
    end else begin
      sample_q <= (phase_q == PH_SAMPLE);
      soc_q    <= (phase_q == PH_START);
    end
  end

  assign capture_o = step_en && (phase_q == PH_CONV) && eoc_s;
  assign sample_o  = sample_q;
  assign soc_o     = soc_q;

  // R2
  ctrl_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(sample_o && soc_o));

  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !step_en |=> $stable(phase_q));

  // R4
  eoc_stall_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (step_en && phase_q == PH_CONV && !eoc_s) |=> (phase_q == PH_CONV));

  // R6
  sample_advance_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (step_en && phase_q == PH_SAMPLE) |=> (phase_q == PH_START));

  // R2
  start_one_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (step_en && phase_q == PH_START) |=> (phase_q == PH_CONV));

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);

  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (load_i) hold_q <= data_i;
  end

  assign data_o = hold_q;

  // R5
  capture_value_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    load_i |=> (data_o == $past(data_i)));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !load_i |=> $stable(data_o));

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              eoc_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              sample_o,
  output logic              soc_o,
  output logic [DATA_W-1:0] result_o
);

  logic rst_ns;
  logic eoc_s;
  logic capture;

  adc_seq_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .d_i    (1'b1),
    .q_o    (rst_ns)
  );

  adc_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_eoc_sync (
    .clk    (clk),
    .arst_n (rst_ns),
    .d_i    (eoc_i),
    .q_o    (eoc_s)
  );

  adc_seq_fsm u_fsm (
    .clk       (clk),
    .rst_ni    (rst_ns),
    .step_en   (step_en),
    .eoc_s     (eoc_s),
    .capture_o (capture),
    .sample_o  (sample_o),
    .soc_o     (soc_o)
  );

  adc_seq_capture #(.DATA_W(DATA_W)) u_capture (
    .clk    (clk),
    .rst_ni (rst_ns),
    .load_i (capture),
    .data_i (conv_data_i),
    .data_o (result_o)
  );

endmodule

// File: tb/adc_seq_top_tb_top.sv
module adc_seq_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       step_en;
  logic       eoc_i;
  logic [7:0] conv_data_i;
  logic       sample_o, soc_o;
  logic [7:0] result_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    logic       s;
    logic       c;
    logic [7:0] r;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  int         m_phase;
  logic       m_eoc;
  logic [7:0] m_res;

  always #2 clk = ~clk;

  adc_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .eoc_i(eoc_i),
    .conv_data_i(conv_data_i), .sample_o(sample_o), .soc_o(soc_o),
    .result_o(result_o)
  );

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual {sample,soc,result}=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input string tag);
    exp_t e;
    e.s = (m_phase == 0);
    e.c = (m_phase == 1);
    e.r = m_res;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, {sample_o, soc_o, result_o}, {e.s, e.c, e.r});
      end
    end
  end

  task automatic set_eoc(input logic v);
    @(negedge clk);
    eoc_i = v;
    m_eoc = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_step(input logic [7:0] d, input string tag);
    @(negedge clk);
    conv_data_i = d;
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    conv_data_i = ~d;   // changes right after the step edge: must not be captured (R5)
    case (m_phase)
      0: m_phase = 1;
      1: m_phase = 2;
      default: if (m_eoc) begin m_res = d; m_phase = 0; end
    endcase
    @(negedge clk);
    push_exp(tag);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 R8 async clear", {sample_o, soc_o, result_o}, 10'h000);
    repeat (3) @(negedge clk);
    check("R1 held in reset", {sample_o, soc_o, result_o}, 10'h000);
    rst_n = 1'b1;
    m_phase = 0;
    m_res = 8'h00;
    repeat (4) @(negedge clk);
    check("R1 sampling after release", {sample_o, soc_o, result_o}, 10'h200);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    step_en = 1'b0;
    eoc_i = 1'b0;
    conv_data_i = 8'h00;
    m_eoc = 1'b0;
    m_phase = 0;
    m_res = 8'h00;
    repeat (2) @(negedge clk);
    do_reset();

    // R3: no step, no change
    repeat (10) @(negedge clk);
    check("R3 idle without step", {sample_o, soc_o, result_o}, 10'h200);

    // R5/R6: normal loops with eoc high throughout
    set_eoc(1'b1);
    do_step(8'hA5, "R6 eoc ignored in sampling, R3 to start");
    do_step(8'h3C, "R6 eoc ignored in start, R3 to conv");
    do_step(8'h5A, "R5 capture and return to sampling");
    do_step(8'h11, "R3 R2 start again");
    do_step(8'h22, "R3 conv again");
    do_step(8'h81, "R5 second capture");
    do_step(8'h00, "R2 start");
    do_step(8'h77, "R2 conv");
    do_step(8'hFF, "R5 capture all ones");

    // R4/R6: stall while eoc low
    set_eoc(1'b0);
    do_step(8'h12, "R2 start");
    do_step(8'h34, "R2 conv");
    for (int i = 0; i < 5; i++) do_step(8'h40 + 8'(i), "R4 R6 stall holds result");
    set_eoc(1'b1);
    do_step(8'h00, "R5 capture all zeros after stall");

    // R7: eoc rising with the step; first two edges still see 0
    set_eoc(1'b0);
    do_step(8'h01, "R2 start");
    do_step(8'h02, "R2 conv");
    @(negedge clk);
    eoc_i = 1'b1;
    step_en = 1'b1;
    conv_data_i = 8'hC3;
    repeat (2) @(negedge clk);
    step_en = 1'b0;
    @(negedge clk);
    check("R7 no capture within two edges", {sample_o, soc_o, result_o}, {2'b00, m_res});
    m_eoc = 1'b1;
    do_step(8'hC3, "R7 capture on third edge");

    // R8: reset in the middle of a conversion
    do_step(8'h10, "R2 start");
    do_step(8'h20, "R2 conv");
    do_reset();
    do_step(8'h99, "R8 first step after reset goes to start");

    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule